// File: doc/BRIEF.md
# Dual-Lane 1:7 Deserializer with Failsafe Outputs

This block turns two serial data lanes into one parallel word. A frame clock travels with the lanes. It is high for four bit periods and low for three. The block runs on a bit clock at seven times the frame rate and samples both lanes and the frame clock on every edge of that bit clock. A rising edge on the frame clock marks a frame boundary. The seven bits that follow on each lane are gathered into one word: lane 0 fills the low half and lane 1 fills the high half. The block then raises a frame-rate output clock. Downstream logic takes the word on the falling edge of that output clock.

Three failsafe rules cover the abnormal cases:
- An idle-detect input marks frames whose lanes carry no real data; such a frame produces an all-ones word.
- If the frame clock stops for longer than a programmable number of bit-clock cycles, the block enters a lost state, holds the last word and lets the output clock fall silent.
- Pulling the enable low clears the block and forces every output low.

The controller has four states:
- OFF: disabled and held clear.
- HUNT: enabled, no frame boundary seen yet.
- RUN: framing and capturing.
- LOST: frame clock timed out.

It has these transitions:
- OFF to HUNT when the enable is high.
- HUNT to RUN on a frame-clock rising edge.
- RUN to LOST when the loss timer expires with no rising edge in that cycle.
- LOST to RUN on the next rising edge.
- Any state to OFF when the enable is low.

Top module: `dual_lane_deser`

## Requirements
- R1: Slot 0 is the lane bit sampled on the first bit-clock edge where `frame_clk` is high after being low. Slots 1 to 6 follow on the next six edges. Lane 0 slot s goes to `data_out[s]` and lane 1 slot s goes to `data_out[7+s]`.
- R2: `data_out` takes the new word on the edge that captures slot 6, which is six edges after slot 0. It then holds that word until the next update.
- R3: `out_clk` rises on the same edge as each word update. It stays high for exactly 4 bit-clock cycles and then goes low, giving one pulse per frame. The word stays stable across the falling edge.
- R4: While `en` is low, from the next edge on, `data_out` is all zeros and `out_clk` is low. Capture state is cleared, and frames received while disabled produce no word and no pulse.
- R5: After `en` returns high, `data_out` stays zero until the first complete frame. A frame cut short by disabling never appears. The block accepts frames from the second edge after `en` rises.
- R6: If `lanes_idle` is high in any slot of a frame, that frame's word is all ones (0x3FFF). The next frame without the flag is decoded normally.
- R7: If no `frame_clk` rising edge is seen for `loss_limit` bit-clock cycles (with `loss_limit` at least 8), the block enters LOST. In LOST, `data_out` holds the last word and `out_clk` stays low. The next rising edge starts a normal frame.
- R8: During reset, `data_out` is zero and `out_clk` is low.
- R9: Back-to-back frames each yield exactly one word, seven bit-clock cycles apart, in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active-high block enable |
| frame_clk | input | 1 | Received frame clock, 4 high / 3 low bit periods |
| lane_in | input | LANES (2) | Serial data lanes, one bit each |
| lanes_idle | input | 1 | Idle-detect flag for the data lanes |
| loss_limit | input | CNT_W (8) | Bit-clock cycles without a frame edge before LOST |
| data_out | output | LANES*SLOTS (14) | Parallel output word |
| out_clk | output | 1 | Frame-rate output clock; word valid at its falling edge |

## Verification
A word is due on `data_out` six bit-clock edges after its slot-0 edge, and `out_clk` falls four edges after that. The scoreboard compares each queued word at the `out_clk` falling edge, sampled half a cycle away from the active edge. One latency test also checks the word exactly one edge after slot 6 is sampled, and checks that the old word is still present just before. Disabling takes one edge to clear the outputs, so those checks sample one negative edge after `en` drops. The loss test waits well beyond `loss_limit` before checking that the word is held.

// File: rtl/deser_pkg.sv
package deser_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RUN  = 2'd2,
        ST_LOST = 2'd3
    } rx_state_t;

endpackage

// File: rtl/deser_lane_cap.sv
module deser_lane_cap #(
    parameter int SLOTS  = 7,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [SLOT_W-1:0] slot,
    input  logic              din,
    output logic [SLOTS-1:0]  frame_bits
);

    logic [SLOTS-1:0] bits_q;

    // current frame image, including the bit arriving this cycle
    always_comb begin
        frame_bits = bits_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (cap && slot == SLOT_W'(i)) frame_bits[i] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bits_q <= '0;
        else if (clr) bits_q <= '0;
        else          bits_q <= frame_bits;
    end

endmodule

// File: rtl/deser_loss_timer.sv
module deser_loss_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             edge_seen,
    input  logic [CNT_W-1:0] limit,
    output logic             lost
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr || edge_seen)  cnt_q <= '0;
        else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
    end

    assign lost = (cnt_q >= limit);

endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
    import deser_pkg::*;
#(
    parameter int SLOTS  = 7,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rise,
    input  logic              lost,
    input  logic              idle_in,
    output logic              cap,
    output logic              last,
    output logic              frame_idle,
    output logic [SLOT_W-1:0] cur_slot,
    output rx_state_t         st
);

    rx_state_t         st_q, st_d;
    logic              busy_q;
    logic              idle_q;
    logic [SLOT_W-1:0] slot_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en) st_d = ST_HUNT;
            ST_HUNT: if (!en) st_d = ST_OFF;
                     else if (rise) st_d = ST_RUN;
            ST_RUN:  if (!en) st_d = ST_OFF;
                     else if (lost && !rise) st_d = ST_LOST;
            ST_LOST: if (!en) st_d = ST_OFF;
                     else if (rise) st_d = ST_RUN;
            default: st_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        cur_slot   = rise ? '0 : slot_q;
        cap        = en && (st_q != ST_OFF) &&
                     (rise || (busy_q && st_q == ST_RUN));
        last       = cap && (cur_slot == SLOT_W'(SLOTS - 1));
        frame_idle = (rise ? 1'b0 : idle_q) | idle_in;
        st         = st_q;
    end

    // slot tracking within a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idle_q <= 1'b0;
            slot_q <= '0;
        end else if (!en) begin
            busy_q <= 1'b0;
            idle_q <= 1'b0;
            slot_q <= '0;
        end else if (cap) begin
            busy_q <= !last;
            idle_q <= frame_idle;
            slot_q <= SLOT_W'(cur_slot + 1'b1);
        end
    end

endmodule

// File: rtl/dual_lane_deser.sv
module dual_lane_deser
    import deser_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int SLOTS      = 7,
    parameter int HIGH_SLOTS = 4,
    parameter int CNT_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   frame_clk,
    input  logic [LANES-1:0]       lane_in,
    input  logic                   lanes_idle,
    input  logic [CNT_W-1:0]       loss_limit,
    output logic [LANES*SLOTS-1:0] data_out,
    output logic                   out_clk
);

    localparam int W      = LANES * SLOTS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int OC_W   = $clog2(HIGH_SLOTS + 1);

    logic              fclk_q;
    logic              rise;
    logic              lost;
    logic              cap;
    logic              last;
    logic              frame_idle;
    logic [SLOT_W-1:0] cur_slot;
    rx_state_t         st;
    logic [W-1:0]      assembled;
    logic [OC_W-1:0]   oc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fclk_q <= 1'b0;
        else        fclk_q <= frame_clk;
    end

    assign rise = frame_clk && !fclk_q;

    deser_ctrl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .rise       (rise),
        .lost       (lost),
        .idle_in    (lanes_idle),
        .cap        (cap),
        .last       (last),
        .frame_idle (frame_idle),
        .cur_slot   (cur_slot),
        .st         (st)
    );

    deser_loss_timer #(.CNT_W(CNT_W)) u_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!en),
        .edge_seen (rise),
        .limit     (loss_limit),
        .lost      (lost)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        deser_lane_cap #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (!en),
            .cap        (cap),
            .slot       (cur_slot),
            .din        (lane_in[g]),
            .frame_bits (assembled[g*SLOTS +: SLOTS])
        );
    end

    // output word register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_out <= '0;
        else if (!en)   data_out <= '0;
        else if (last)  data_out <= frame_idle ? '1 : assembled;
    end

    // frame-rate output clock: HIGH_SLOTS cycles high from each update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_clk <= 1'b0;
            oc_cnt  <= '0;
        end else if (!en) begin
            out_clk <= 1'b0;
            oc_cnt  <= '0;
        end else if (last) begin
            out_clk <= 1'b1;
            oc_cnt  <= OC_W'(1);
        end else if (out_clk) begin
            if (oc_cnt == OC_W'(HIGH_SLOTS)) out_clk <= 1'b0;
            else                             oc_cnt  <= oc_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/deser_chk.sv
module deser_chk
    import deser_pkg::*;
#(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         out_clk,
    input logic [W-1:0] data_out,
    input rx_state_t    st
);

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (data_out == '0 && !out_clk));

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_clk && $past(out_clk) && $past(out_clk, 2) && $past(out_clk, 3)) |=> !out_clk);

    assert_word_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> ($rose(out_clk) || !$past(en)));

    assert_lost_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOST && $past(st) == ST_LOST) |-> $stable(data_out));

    assert_lost_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOST && $past(st) == ST_LOST) |-> !$rose(out_clk));

endmodule

bind dual_lane_deser deser_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .out_clk  (out_clk),
    .data_out (data_out),
    .st       (st)
);

// File: tb/tb_dual_lane_deser.sv
module tb_dual_lane_deser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic        frame_clk;
    logic [1:0]  lane_in;
    logic        lanes_idle;
    logic [7:0]  loss_limit;
    logic [13:0] data_out;
    logic        out_clk;

    logic [13:0] exp_q[$];
    string       tag_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [13:0] last_word = '0;

    always #2 clk = ~clk;

    dual_lane_deser dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .frame_clk  (frame_clk),
        .lane_in    (lane_in),
        .lanes_idle (lanes_idle),
        .loss_limit (loss_limit),
        .data_out   (data_out),
        .out_clk    (out_clk)
    );

    task automatic check(input bit ok, input string req,
                         input logic [13:0] act, input logic [13:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // serializer model: drives nslots slots of one frame, slot 0 first
    task automatic send_frame(input logic [13:0] w, input int idle_slot,
                              input bit expect_out, input int nslots,
                              input string tag);
        if (expect_out) begin
            exp_q.push_back((idle_slot >= 0) ? 14'h3FFF : w);
            tag_q.push_back(tag);
            last_word = (idle_slot >= 0) ? 14'h3FFF : w;
        end
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            frame_clk  = (s < 4);
            lane_in[0] = w[s];
            lane_in[1] = w[7 + s];
            lanes_idle = (s == idle_slot);
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_clk  = 1'b0;
            lane_in    = 2'($urandom);
            lanes_idle = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: compare at each out_clk falling edge, check pulse width
    logic prev_oc = 1'b0;
    int   hi_cnt  = 0;
    always @(negedge clk) begin
        if (prev_oc && !out_clk) begin
            check(hi_cnt == 4, "R3 out_clk high cycles", 14'(hi_cnt), 14'd4);
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected word", data_out, 14'h0);
            end else begin
                logic [13:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(data_out === e, t, data_out, e);
            end
        end
        hi_cnt  = out_clk ? hi_cnt + 1 : 0;
        prev_oc = out_clk;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 14'h0, 14'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; frame_clk = 1'b0; lane_in = '0;
        lanes_idle = 1'b0; loss_limit = 8'd20;
        repeat (3) @(negedge clk);
        check(data_out == '0 && !out_clk, "R8 reset state", data_out, 14'h0);
        rst_n = 1'b1;
        en    = 1'b1;
        gap(3);

        // R1 bit mapping
        send_frame(14'h0001, -1, 1, 7, "R1 lane0 slot0 -> bit0");
        send_frame(14'h0080, -1, 1, 7, "R1 lane1 slot0 -> bit7");
        send_frame(14'h2040, -1, 1, 7, "R1 slot6 both lanes");
        // R9 back-to-back stream
        for (int i = 0; i < 5; i++)
            send_frame(14'($urandom), -1, 1, 7, "R9 back-to-back word");
        gap(12);
        drain();

        // R2 latency: word lands on the edge sampling slot 6
        begin
            logic [13:0] prev, w;
            prev = last_word;
            w    = 14'h1A5C;
            send_frame(w, -1, 1, 7, "R2 word at out_clk fall");
            check(data_out == prev, "R2 old word held before slot 6 edge", data_out, prev);
            @(negedge clk);
            frame_clk = 1'b0;
            check(data_out == w, "R2 word one edge after slot 6", data_out, w);
        end
        gap(12);
        drain();

        // R6 idle frame then normal frame
        send_frame(14'h1234, 3, 1, 7, "R6 idle frame all ones");
        send_frame(14'h0ABC, -1, 1, 7, "R6 normal frame after idle");
        gap(12);
        drain();

        // R7 clock loss
        gap(40);
        check(data_out == last_word, "R7 word held in lost state", data_out, last_word);
        check(!out_clk, "R7 out_clk low in lost state", 14'(out_clk), 14'h0);
        send_frame(14'h3C0F, -1, 1, 7, "R7 frame after clock returns");
        gap(12);
        drain();

        // R4 disable
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(data_out == '0 && !out_clk, "R4 outputs low one edge after disable", data_out, 14'h0);
        send_frame(14'h3FFE, -1, 0, 7, "R4");
        send_frame(14'h1555, -1, 0, 7, "R4");
        gap(12);
        check(data_out == '0 && !out_clk, "R4 frames ignored while disabled", data_out, 14'h0);

        // R5 re-enable, partial frame discarded
        en = 1'b1;
        gap(3);
        check(data_out == '0, "R5 zero after re-enable", data_out, 14'h0);
        send_frame(14'h2AAA, -1, 0, 3, "R5");
        @(negedge clk);
        frame_clk = 1'b0;
        en = 1'b0;
        gap(3);
        en = 1'b1;
        gap(12);
        check(data_out == '0 && !out_clk, "R5 cut frame never appears", data_out, 14'h0);
        send_frame(14'h0F0F, -1, 1, 7, "R5 first word after re-enable");
        gap(12);
        drain();

        check(exp_q.size() == 0, "R9 all words delivered", 14'(exp_q.size()), 14'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule